// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block collects fourteen interrupt requests for a small 8-bit processor and chooses the one to serve. The requests come from four groups. Two are external pins, and each pin can be set as active-low level-sensitive or as falling-edge triggered. Four are capture pins, and each can trigger on the rising edge, the falling edge or both. The other eight are single-cycle event pulses from on-chip peripherals: three timer overflows, three compare matches, ADC completion and the UART. Each source has its own enable bit and its own priority bit. A global enable gates every source at once.

The block presents the winning request to the processor as a registered strobe with a program-memory vector address. That pair stays frozen until the processor acknowledges it. Two in-service flags, one for each level, track which handlers are running. This lets a low-level handler be preempted by a high-level request. A running high-level handler cannot be preempted at all. A return input ends the innermost running handler.

Top module: `nested_irq_ctrl`

## Requirements
- R1: Each source has an index, and that index also sets its same-level rank: 0 X0 (external 0), 1 ADC, 2 T0, 3 CT0, 4 CM0, 5 X1 (external 1), 6 CT1, 7 CM1, 8 T1, 9 CT2, 10 CM2, 11 S0 (UART), 12 CT3, 13 T2. Bit i of `src_en` and bit i of `src_hi` belong to source i. A source raises the strobe only while its `src_en` bit is 1 and `glob_en` is 1.
- R2: When eligible requests are pending at both levels, a source whose `src_hi` bit is 1 wins over any source whose bit is 0.
- R3: Among eligible requests of the same level, the lowest index from R1 wins.
- R4: Vector addresses are X0 0003h, T0 000Bh, X1 0013h, T1 001Bh, S0 0023h, CT0 0033h, CT1 003Bh, CT2 0043h, CT3 004Bh, ADC 0053h, CM0 005Bh, CM1 0063h, CM2 006Bh, T2 0073h. Every vector ends in binary 011.
- R5: `irq_req` and `irq_vec` are registered. Once `irq_req` is raised, both hold unchanged until a cycle with `irq_ack` high. That acknowledge drops `irq_req` in the next cycle. An `irq_ack` given while `irq_req` is low has no effect.
- R6: `in_service[0]` is the low-level flag and `in_service[1]` is the high-level flag. An accepted acknowledge sets the flag of the served level. `irq_ret` clears the high flag if it is set, and otherwise clears the low flag. `irq_ret` with no flag set has no effect.
- R7: While the low flag is set, only high-level sources may raise the strobe. While the high flag is set, no source may raise it.
- R8: External pin k (`ext_pin_n[k]`, active low) has two modes. When `ext_edge_mode[k]` is 0, its request follows the low pin and is not latched. When `ext_edge_mode[k]` is 1, a falling edge latches a request.
- R9: Capture pin k latches a request on a rising edge when `cap_rise_en[k]` is 1, and on a falling edge when `cap_fall_en[k]` is 1. With both bits set it latches on both edges.
- R10: Bits 0..7 of `evt_pulse` latch T0, T1, T2, CM0, CM1, CM2, ADC and S0 respectively. A latched request stays pending while its source is disabled. It is cleared only by the acknowledge of its own vector, and a new event arriving in that same cycle wins over the clear.
- R11: Pins pass through a two-stage synchronizer. The strobe rises three clock edges after a pin change in level mode, and four edges after a change in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 2 | External request pins, active low |
| ext_edge_mode | input | 2 | 1 = falling-edge mode, 0 = low-level mode, one bit per pin |
| cap_pin | input | 4 | Capture pins |
| cap_rise_en | input | 4 | Rising-edge trigger enable for each capture pin |
| cap_fall_en | input | 4 | Falling-edge trigger enable for each capture pin |
| evt_pulse | input | 8 | Peripheral event pulses, mapped as in R10 |
| src_en | input | 14 | Enable bit for each source |
| src_hi | input | 14 | Priority bit for each source, 1 = high level |
| glob_en | input | 1 | Global enable |
| irq_ack | input | 1 | Processor accepts the presented vector |
| irq_ret | input | 1 | Processor returns from a handler |
| irq_req | output | 1 | Request strobe to the processor |
| irq_vec | output | ADDR_W | Vector address of the presented request |
| in_service | output | 2 | In-service flags: bit 0 low level, bit 1 high level |

## Verification
A wrong internal state in this block shows at the ports within a few cycles. A latched flag that fails to clear reappears as a fresh strobe with the same vector two edges after the return. A stale in-service flag appears at once on `in_service`, and it also withholds or admits a strobe on the next eligible request. A broken synchronizer or edge detector moves the strobe edge by at least one cycle or suppresses it. The reference model therefore compares strobe, vector and both flags on every clock, so a divergence is caught in the cycle it first becomes visible.

// File: rtl/nirq_pkg.sv
`timescale 1ns/1ps
package nirq_pkg;
   localparam int N_SRC = 14;
   localparam int IDX_W = 4;
   localparam int N_EXT = 2;
   localparam int N_CAP = 4;
   localparam int N_EVT = 8;

   typedef logic [IDX_W-1:0] src_idx_t;

   // index equals same-level rank (lower wins)
   localparam src_idx_t IDX_X0  = 4'd0;
   localparam src_idx_t IDX_ADC = 4'd1;
   localparam src_idx_t IDX_T0  = 4'd2;
   localparam src_idx_t IDX_CT0 = 4'd3;
   localparam src_idx_t IDX_CM0 = 4'd4;
   localparam src_idx_t IDX_X1  = 4'd5;
   localparam src_idx_t IDX_CT1 = 4'd6;
   localparam src_idx_t IDX_CM1 = 4'd7;
   localparam src_idx_t IDX_T1  = 4'd8;
   localparam src_idx_t IDX_CT2 = 4'd9;
   localparam src_idx_t IDX_CM2 = 4'd10;
   localparam src_idx_t IDX_S0  = 4'd11;
   localparam src_idx_t IDX_CT3 = 4'd12;
   localparam src_idx_t IDX_T2  = 4'd13;

   // vector = {slot, 3'b011}; slot 5 is left unused
   function automatic logic [3:0] vec_slot(input src_idx_t i);
      case (i)
         IDX_X0:  return 4'd0;
         IDX_T0:  return 4'd1;
         IDX_X1:  return 4'd2;
         IDX_T1:  return 4'd3;
         IDX_S0:  return 4'd4;
         IDX_CT0: return 4'd6;
         IDX_CT1: return 4'd7;
         IDX_CT2: return 4'd8;
         IDX_CT3: return 4'd9;
         IDX_ADC: return 4'd10;
         IDX_CM0: return 4'd11;
         IDX_CM1: return 4'd12;
         IDX_CM2: return 4'd13;
         IDX_T2:  return 4'd14;
         default: return 4'd15;
      endcase
   endfunction

   function automatic src_idx_t ext_idx(input int k);
      return (k == 0) ? IDX_X0 : IDX_X1;
   endfunction

   function automatic src_idx_t cap_idx(input int k);
      case (k)
         0:       return IDX_CT0;
         1:       return IDX_CT1;
         2:       return IDX_CT2;
         default: return IDX_CT3;
      endcase
   endfunction

   function automatic src_idx_t evt_idx(input int k);
      case (k)
         0:       return IDX_T0;
         1:       return IDX_T1;
         2:       return IDX_T2;
         3:       return IDX_CM0;
         4:       return IDX_CM1;
         5:       return IDX_CM2;
         6:       return IDX_ADC;
         default: return IDX_S0;
      endcase
   endfunction
endpackage

// File: rtl/nirq_sync.sv
`timescale 1ns/1ps
module nirq_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nirq_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("nirq_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain;
   logic [W-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= {STAGES{RST_VAL}};
         prev_q <= RST_VAL;
      end else begin
         chain  <= {chain[STAGES-2:0], d};
         prev_q <= chain[STAGES-1];
      end
   end

   assign q      = chain[STAGES-1];
   assign q_prev = prev_q;
endmodule

// File: rtl/nirq_pend.sv
`timescale 1ns/1ps
module nirq_pend import nirq_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] ext_s,
   input  logic [N_EXT-1:0] ext_d,
   input  logic [N_EXT-1:0] ext_edge_mode,
   input  logic [N_CAP-1:0] cap_s,
   input  logic [N_CAP-1:0] cap_d,
   input  logic [N_CAP-1:0] cap_rise_en,
   input  logic [N_CAP-1:0] cap_fall_en,
   input  logic [N_EVT-1:0] evt_pulse,
   input  logic             clr_vld,
   input  src_idx_t         clr_idx,
   output logic [N_SRC-1:0] pend
);
   logic [N_SRC-1:0] set_ev;
   logic [N_SRC-1:0] lvl_sel;
   logic [N_SRC-1:0] lvl_req;
   logic [N_SRC-1:0] flag;

   always_comb begin
      set_ev  = '0;
      lvl_sel = '0;
      lvl_req = '0;
      for (int k = 0; k < N_EXT; k++) begin
         if (ext_edge_mode[k]) begin
            set_ev[ext_idx(k)] = ext_d[k] & ~ext_s[k];
         end else begin
            lvl_sel[ext_idx(k)] = 1'b1;
            lvl_req[ext_idx(k)] = ~ext_s[k];
         end
      end
      for (int k = 0; k < N_CAP; k++) begin
         set_ev[cap_idx(k)] = (cap_rise_en[k] &  cap_s[k] & ~cap_d[k]) |
                              (cap_fall_en[k] & ~cap_s[k] &  cap_d[k]);
      end
      for (int k = 0; k < N_EVT; k++) begin
         set_ev[evt_idx(k)] = evt_pulse[k];
      end
   end

   // new event beats the acknowledge clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= '0;
      end else begin
         for (int i = 0; i < N_SRC; i++) begin
            if (set_ev[i])
               flag[i] <= 1'b1;
            else if (lvl_sel[i] || (clr_vld && clr_idx == IDX_W'(i)))
               flag[i] <= 1'b0;
         end
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_pend
      assign pend[i] = lvl_sel[i] ? lvl_req[i] : flag[i];
   end

   for (genvar k = 0; k < N_EVT; k++) begin : g_evt_chk
      localparam src_idx_t EI = evt_idx(k);
      assert_evt_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
         evt_pulse[k] |=> pend[EI]);
   end
endmodule

// File: rtl/nirq_arb.sv
`timescale 1ns/1ps
module nirq_arb import nirq_pkg::*; #(
   parameter int N = N_SRC
) (
   input  logic [N-1:0] pend,
   input  logic [N-1:0] src_en,
   input  logic [N-1:0] src_hi,
   input  logic         glob_en,
   input  logic         svc_lo,
   input  logic         svc_hi,
   output logic         win_vld,
   output src_idx_t     win_idx,
   output logic         win_hi
);
   if (N > (1 << IDX_W)) begin : g_bad_n
      $error("nirq_arb: N exceeds index width");
   end

   logic [N-1:0] cand_hi;
   logic [N-1:0] cand_lo;
   logic [N-1:0] pick;
   logic         open_hi;
   logic         open_lo;

   assign open_hi = glob_en & ~svc_hi;
   assign open_lo = open_hi & ~svc_lo;

   for (genvar i = 0; i < N; i++) begin : g_cand
      assign cand_hi[i] = pend[i] & src_en[i] &  src_hi[i] & open_hi;
      assign cand_lo[i] = pend[i] & src_en[i] & ~src_hi[i] & open_lo;
   end

   assign win_hi  = |cand_hi;
   assign pick    = win_hi ? cand_hi : cand_lo;
   assign win_vld = |pick;

   always_comb begin
      win_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pick[i]) win_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/nested_irq_ctrl.sv
`timescale 1ns/1ps
module nested_irq_ctrl import nirq_pkg::*; #(
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EXT-1:0]  ext_pin_n,
   input  logic [N_EXT-1:0]  ext_edge_mode,
   input  logic [N_CAP-1:0]  cap_pin,
   input  logic [N_CAP-1:0]  cap_rise_en,
   input  logic [N_CAP-1:0]  cap_fall_en,
   input  logic [N_EVT-1:0]  evt_pulse,
   input  logic [N_SRC-1:0]  src_en,
   input  logic [N_SRC-1:0]  src_hi,
   input  logic              glob_en,
   input  logic              irq_ack,
   input  logic              irq_ret,
   output logic              irq_req,
   output logic [ADDR_W-1:0] irq_vec,
   output logic [1:0]        in_service
);
   localparam int VEC_BITS = 7;

   if (ADDR_W < VEC_BITS) begin : g_bad_addr
      $error("nested_irq_ctrl: ADDR_W too small for vector map");
   end

   logic [N_EXT-1:0] ext_s, ext_d;
   logic [N_CAP-1:0] cap_s, cap_d;
   logic [N_SRC-1:0] pend;
   logic             win_vld, win_hi;
   src_idx_t         win_idx;

   logic              req_q;
   logic [ADDR_W-1:0] vec_q;
   src_idx_t          idx_q;
   logic              hi_q;
   logic [1:0]        svc_q, svc_n;
   logic              ack_take;

   nirq_sync #(.W(N_EXT), .STAGES(SYNC_STAGES), .RST_VAL({N_EXT{1'b1}})) u_sync_ext (
      .clk(clk), .rst_n(rst_n), .d(ext_pin_n), .q(ext_s), .q_prev(ext_d));

   nirq_sync #(.W(N_CAP), .STAGES(SYNC_STAGES), .RST_VAL({N_CAP{1'b0}})) u_sync_cap (
      .clk(clk), .rst_n(rst_n), .d(cap_pin), .q(cap_s), .q_prev(cap_d));

   assign ack_take = req_q & irq_ack;

   nirq_pend u_pend (
      .clk(clk), .rst_n(rst_n),
      .ext_s(ext_s), .ext_d(ext_d), .ext_edge_mode(ext_edge_mode),
      .cap_s(cap_s), .cap_d(cap_d),
      .cap_rise_en(cap_rise_en), .cap_fall_en(cap_fall_en),
      .evt_pulse(evt_pulse),
      .clr_vld(ack_take), .clr_idx(idx_q),
      .pend(pend));

   nirq_arb #(.N(N_SRC)) u_arb (
      .pend(pend), .src_en(src_en), .src_hi(src_hi), .glob_en(glob_en),
      .svc_lo(svc_q[0]), .svc_hi(svc_q[1]),
      .win_vld(win_vld), .win_idx(win_idx), .win_hi(win_hi));

   // return ends the innermost level, then an accepted ack opens its level
   always_comb begin
      svc_n = svc_q;
      if (irq_ret) begin
         if (svc_q[1]) svc_n[1] = 1'b0;
         else          svc_n[0] = 1'b0;
      end
      if (ack_take) svc_n[hi_q] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         vec_q <= '0;
         idx_q <= '0;
         hi_q  <= 1'b0;
         svc_q <= 2'b00;
      end else begin
         svc_q <= svc_n;
         if (req_q) begin
            if (irq_ack) req_q <= 1'b0;
         end else if (win_vld) begin
            req_q <= 1'b1;
            vec_q <= ADDR_W'({vec_slot(win_idx), 3'b011});
            idx_q <= win_idx;
            hi_q  <= win_hi;
         end
      end
   end

   assign irq_req    = req_q;
   assign irq_vec    = vec_q;
   assign in_service = svc_q;

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

   assert_idle_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack && !irq_req && !irq_ret |=> $stable(in_service));

   assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(glob_en));

   assert_vec_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_vec[2:0] == 3'b011);

   assert_ret_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ret && in_service[1] && !irq_ack |=>
         !in_service[1] && in_service[0] == $past(in_service[0]));

   assert_hi_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_service[1] |-> !irq_req);

   assert_lo_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) && in_service[0] |-> hi_q);
endmodule

// File: tb/nested_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nested_irq_ctrl_bench;
   localparam int AW = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic [1:0]  ext_pin_n, ext_edge_mode;
   logic [3:0]  cap_pin, cap_rise_en, cap_fall_en;
   logic [7:0]  evt_pulse;
   logic [13:0] src_en, src_hi;
   logic        glob_en, irq_ack, irq_ret;
   wire         irq_req;
   wire [AW-1:0] irq_vec;
   wire [1:0]   in_service;

   int    n_tests = 0;
   int    n_fail  = 0;
   string tag     = "R5";

   nested_irq_ctrl #(.ADDR_W(AW), .SYNC_STAGES(2)) u_nested_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
      .cap_pin(cap_pin), .cap_rise_en(cap_rise_en), .cap_fall_en(cap_fall_en),
      .evt_pulse(evt_pulse), .src_en(src_en), .src_hi(src_hi), .glob_en(glob_en),
      .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec),
      .in_service(in_service));

   // reference model
   int vtab[14]  = '{'h03, 'h53, 'h0B, 'h33, 'h5B, 'h13, 'h3B, 'h63, 'h1B, 'h43, 'h6B, 'h23, 'h4B, 'h73};
   int extmap[2] = '{0, 5};
   int capmap[4] = '{3, 6, 9, 12};
   int evmap[8]  = '{2, 8, 13, 4, 7, 10, 1, 11};
   bit e1[2], e2[2], ed[2];
   bit c1[4], c2[4], cd[4];
   bit flag[14];
   bit m_req, m_hi, m_slo, m_shi;
   int m_vec, m_idx;

   always @(posedge clk) begin : model
      bit pend[14];
      bit nflag[14];
      int win;
      bit winhi;
      bit nlo, nhi;
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin e1[k] = 1; e2[k] = 1; ed[k] = 1; end
         for (int k = 0; k < 4; k++) begin c1[k] = 0; c2[k] = 0; cd[k] = 0; end
         for (int i = 0; i < 14; i++) flag[i] = 0;
         m_req = 0; m_hi = 0; m_slo = 0; m_shi = 0; m_vec = 0; m_idx = 0;
      end else begin
         for (int i = 0; i < 14; i++) pend[i] = flag[i];
         for (int k = 0; k < 2; k++) if (!ext_edge_mode[k]) pend[extmap[k]] = !e2[k];
         win = -1; winhi = 0;
         if (glob_en && !m_shi) begin
            for (int i = 0; i < 14 && win < 0; i++)
               if (pend[i] && src_en[i] && src_hi[i]) win = i;
            if (win >= 0) winhi = 1;
            else if (!m_slo)
               for (int i = 0; i < 14 && win < 0; i++)
                  if (pend[i] && src_en[i] && !src_hi[i]) win = i;
         end
         nflag = flag;
         if (m_req && irq_ack) nflag[m_idx] = 0;
         for (int k = 0; k < 2; k++) begin
            if (!ext_edge_mode[k]) nflag[extmap[k]] = 0;
            else if (ed[k] && !e2[k]) nflag[extmap[k]] = 1;
         end
         for (int k = 0; k < 4; k++) begin
            if (cap_rise_en[k] && !cd[k] && c2[k]) nflag[capmap[k]] = 1;
            if (cap_fall_en[k] && cd[k] && !c2[k]) nflag[capmap[k]] = 1;
         end
         for (int k = 0; k < 8; k++) if (evt_pulse[k]) nflag[evmap[k]] = 1;
         nlo = m_slo; nhi = m_shi;
         if (irq_ret) begin
            if (m_shi) nhi = 0; else nlo = 0;
         end
         if (m_req && irq_ack) begin
            if (m_hi) nhi = 1; else nlo = 1;
         end
         if (m_req) begin
            if (irq_ack) m_req = 0;
         end else if (win >= 0) begin
            m_req = 1; m_vec = vtab[win]; m_idx = win; m_hi = winhi;
         end
         m_slo = nlo; m_shi = nhi;
         flag = nflag;
         for (int k = 0; k < 2; k++) begin ed[k] = e2[k]; e2[k] = e1[k]; e1[k] = ext_pin_n[k]; end
         for (int k = 0; k < 4; k++) begin cd[k] = c2[k]; c2[k] = c1[k]; c1[k] = cap_pin[k]; end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_tests++;
         if (irq_req !== m_req || (m_req && irq_vec !== AW'(m_vec)) ||
             in_service !== {m_shi, m_slo}) begin
            n_fail++;
            $display("FAIL %s model: req=%0b vec=%h svc=%b expected req=%0b vec=%h svc=%b",
                     tag, irq_req, irq_vec, in_service, m_req, AW'(m_vec), {m_shi, m_slo});
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic [7:0] m);
      evt_pulse = m; tick(1); evt_pulse = '0;
   endtask

   task automatic do_ack();
      irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
   endtask

   task automatic do_ret();
      irq_ret = 1'b1; tick(1); irq_ret = 1'b0;
   endtask

   task automatic expect_out(input bit req, input int vec, input logic [1:0] svc, input string rq);
      n_tests++;
      if (irq_req !== req || (req && irq_vec !== AW'(vec)) || in_service !== svc) begin
         n_fail++;
         $display("FAIL %s: req=%0b vec=%h svc=%b expected req=%0b vec=%h svc=%b",
                  rq, irq_req, irq_vec, in_service, req, AW'(vec), svc);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #(8 * 50000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 0; ext_pin_n = 2'b11; ext_edge_mode = 2'b00; cap_pin = '0;
      cap_rise_en = '0; cap_fall_en = '0; evt_pulse = '0; src_en = '1; src_hi = '0;
      glob_en = 0; irq_ack = 0; irq_ret = 0;
      tick(3);
      expect_out(0, 0, 2'b00, "R5 reset");
      rst_n = 1;
      tick(2);

      // R1 global gate, R4 vector, R6 flags
      tag = "R1";
      pulse(8'h01); tick(3);
      expect_out(0, 0, 2'b00, "R1 global off");
      glob_en = 1; tick(3);
      expect_out(1, 'h0B, 2'b00, "R4 T0 vector");
      do_ack(); expect_out(0, 0, 2'b01, "R6 low set");
      do_ret(); expect_out(0, 0, 2'b00, "R6 low cleared");

      // R3 same-level order
      tag = "R3";
      pulse(8'h41); tick(3);
      expect_out(1, 'h53, 2'b00, "R3 ADC before T0");
      do_ack(); do_ret(); tick(3);
      expect_out(1, 'h0B, 2'b00, "R3 T0 next");
      do_ack(); do_ret();

      // R2 high beats low
      tag = "R2";
      src_hi[8] = 1;
      pulse(8'h03); tick(3);
      expect_out(1, 'h1B, 2'b00, "R2 T1 high wins");
      do_ack(); expect_out(0, 0, 2'b10, "R6 high set");
      do_ret(); tick(3);
      expect_out(1, 'h0B, 2'b00, "R2 low after");
      do_ack(); do_ret();

      // R7 nesting, R6 return order
      tag = "R7";
      src_hi[13] = 1; src_hi[11] = 1;
      pulse(8'h01); tick(3);
      expect_out(1, 'h0B, 2'b00, "R7 low start");
      do_ack(); expect_out(0, 0, 2'b01, "R6 low running");
      pulse(8'h08); tick(3);
      expect_out(0, 0, 2'b01, "R7 low blocked by low");
      pulse(8'h04); tick(3);
      expect_out(1, 'h73, 2'b01, "R7 high preempts");
      do_ack(); expect_out(0, 0, 2'b11, "R7 both levels");
      pulse(8'h80); tick(3);
      expect_out(0, 0, 2'b11, "R7 high not preempted");
      do_ret(); expect_out(0, 0, 2'b01, "R6 high cleared first");
      tick(2);
      expect_out(1, 'h23, 2'b01, "R7 S0 after return");
      do_ack(); do_ret(); tick(2);
      expect_out(0, 0, 2'b01, "R7 CM0 still blocked");
      do_ret(); tick(3);
      expect_out(1, 'h5B, 2'b00, "R3 CM0 served");
      do_ack(); do_ret(); tick(2);

      // R8 level mode on X1
      tag = "R8";
      ext_pin_n[1] = 0; tick(4);
      expect_out(1, 'h13, 2'b00, "R8 X1 level");
      do_ack(); do_ret(); tick(3);
      expect_out(1, 'h13, 2'b00, "R8 X1 level again");
      ext_pin_n[1] = 1; tick(5);
      expect_out(1, 'h13, 2'b00, "R5 held after pin release");
      do_ack(); do_ret(); tick(5);
      expect_out(0, 0, 2'b00, "R8 level not latched");

      // R11 latency, R8 edge mode on X0
      tag = "R11";
      ext_edge_mode[0] = 1; tick(2);
      ext_pin_n[0] = 0; tick(3);
      expect_out(0, 0, 2'b00, "R11 no strobe after 3 edges");
      tick(1);
      expect_out(1, 'h03, 2'b00, "R11 strobe after 4 edges");
      do_ack(); do_ret(); tick(5);
      expect_out(0, 0, 2'b00, "R8 edge latch cleared");
      ext_pin_n[0] = 1; tick(4);

      // R9 capture edges
      tag = "R9";
      cap_rise_en = 4'b0110; cap_fall_en = 4'b0100;
      cap_pin[0] = 1; tick(5);
      expect_out(0, 0, 2'b00, "R9 CT0 no enable");
      cap_pin[1] = 1; tick(5);
      expect_out(1, 'h3B, 2'b00, "R9 CT1 rise");
      do_ack(); do_ret();
      cap_pin[1] = 0; tick(5);
      expect_out(0, 0, 2'b00, "R9 CT1 fall ignored");
      cap_pin[2] = 1; tick(5);
      expect_out(1, 'h43, 2'b00, "R9 CT2 rise");
      do_ack(); do_ret();
      cap_pin[2] = 0; tick(5);
      expect_out(1, 'h43, 2'b00, "R9 CT2 fall");
      do_ack(); do_ret(); tick(2);

      // R1 per-source enable, R10 latched while disabled
      tag = "R10";
      src_en[13] = 0;
      pulse(8'h04); tick(3);
      expect_out(0, 0, 2'b00, "R1 T2 disabled");
      src_en[13] = 1; tick(3);
      expect_out(1, 'h73, 2'b00, "R10 kept pending");
      do_ack(); do_ret(); tick(2);

      // R5/R6 idle ack and return ignored
      tag = "R5";
      do_ack(); expect_out(0, 0, 2'b00, "R5 idle ack");
      do_ret(); expect_out(0, 0, 2'b00, "R6 idle return");

      // R5 hold against a better request, R10 clear on ack
      pulse(8'h20); tick(3);
      expect_out(1, 'h6B, 2'b00, "R5 CM2 presented");
      pulse(8'h40); tick(4);
      expect_out(1, 'h6B, 2'b00, "R5 vector held");
      do_ack(); do_ret(); tick(3);
      expect_out(1, 'h53, 2'b00, "R10 ADC served next");
      do_ack(); do_ret(); tick(3);
      expect_out(0, 0, 2'b00, "R10 flag cleared by ack");

      tick(2);
      summary();
      $finish;
   end
endmodule